// File: doc/BRIEF.md
# Matrix Key Event Reporter

This block turns snapshots of a keyboard matrix scan into a stream of key events. Each snapshot holds up to eight valid entries. Each entry names a key by row and column. The block looks up a keycode for every entry in a loadable keycode map. It compares the resulting set with the set it reported last time. It then emits a release event for every key that has gone away, followed by a scan-code event and a press event for every key in the new set.

Two optional behaviours sit between lookup and reporting:

- **Ghost filter.** Matrix keyboards show phantom keys when three pressed keys form the corners of a rectangle. With the ghost filter enabled, the block drops a snapshot that looks like such a pattern. A dropped snapshot produces no events and leaves the stored set as it was.
- **Function layer.** With function-layer mode on, a key whose base keycode equals the function keycode is swallowed. Every other key of that snapshot is then looked up in the upper half of the map.

Events leave one per cycle on a valid/ready handshake. The block does not accept a new snapshot until every event of the current one has been taken. The map is loaded through a plain address/data/write-enable port.

Top module: `key_event_reporter`

## Requirements
- R1: After reset `snap_ready` is 1, `ev_valid` is 0, and the stored key set is empty, so the first snapshot produces press-side events only.
- R2: A key entry is 7 bits, row in bits [6:3] and column in bits [2:0]; its scan index equals that value. Entry k of `snap_keys` sits at bits [7k+6:7k], and `snap_count` above 8 is treated as 8.
- R3: In the base layer a key's keycode is the map word at address {0, scan index}. The map is written when `map_we` is 1 at a clock edge, and words written are used by later snapshots.
- R4: Every keycode in the stored set that does not appear among the new keycodes yields one release event (`ev_kind` 0, `ev_code` the keycode), in stored order. All release events come before any scan or press event of the same snapshot.
- R5: Each reported key, in snapshot order, yields a scan event (`ev_kind` 2, `ev_code` the 8-bit map address: bit 7 is the bank, bits 6:0 the scan index), immediately followed by a press event (`ev_kind` 1, `ev_code` the keycode).
- R6: After the events of an accepted snapshot, the stored set becomes that snapshot's keycode list.
- R7: With `cfg_ghost_en` 1 and at least 3 reported keys, a snapshot is dropped if any two keys share a column and any two keys share a row. A dropped snapshot emits no event and leaves the stored set unchanged.
- R8: With `cfg_ghost_en` 0, or with fewer than 3 reported keys, no snapshot is dropped.
- R9: With `cfg_fn_en` 1 and a key whose base keycode equals FN_CODE (default 0x01D0) in the snapshot, that key is not reported. Every other key instead uses map address {1, scan index}, and its scan event carries that address.
- R10: With `cfg_fn_en` 0, a key mapping to FN_CODE is reported like any other key.
- R11: A snapshot with count 0 releases every stored key and leaves the stored set empty.
- R12: While `ev_valid` is 1 and `ev_ready` is 0, `ev_kind` and `ev_code` hold. `snap_ready` stays 0 until all events of the current snapshot have been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ghost_en | input | 1 | Enable ghost-pattern dropping |
| cfg_fn_en | input | 1 | Enable function-layer remapping |
| map_we | input | 1 | Keycode map write enable |
| map_waddr | input | 8 | Keycode map write address (bank, scan index) |
| map_wdata | input | 16 | Keycode map write data |
| snap_valid | input | 1 | Snapshot offered |
| snap_ready | output | 1 | Block idle and able to take a snapshot |
| snap_count | input | 4 | Number of valid entries in the snapshot |
| snap_keys | input | 56 | Eight packed 7-bit key entries |
| ev_valid | output | 1 | Event present |
| ev_ready | input | 1 | Event consumer accepts |
| ev_kind | output | 2 | 0 release, 1 press, 2 scan code |
| ev_code | output | 16 | Keycode, or map address for scan events |

## Verification
The hardest case to reach from the ports is a ghost pattern in which the row-sharing pair and the column-sharing pair are different keys. Here the rule drops the snapshot even though no single key closes a rectangle. A directed snapshot builds exactly that case. A following snapshot then shows, through its release events, that the stored set was left untouched. A second hard case is a function-layer snapshot observed while the consumer stalls: there the first event must sit still with `snap_ready` low. The bench holds `ev_ready` low for many cycles in that state. Random snapshots with function keys mixed in, random flags and random back-pressure cover the remaining orderings against a bench model.

// File: rtl/kev_pkg.sv
package kev_pkg;
  typedef enum logic [1:0] {
    EV_RELEASE = 2'd0,
    EV_PRESS   = 2'd1,
    EV_SCAN    = 2'd2
  } ev_kind_t;
endpackage

// File: rtl/kev_keymap.sv
module kev_keymap #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // simple dual-port: one write, one registered read
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/kev_ghost.sv
module kev_ghost #(
  parameter int MAXK  = 8,
  parameter int ROW_W = 4,
  parameter int COL_W = 3
) (
  input  logic [MAXK*(ROW_W+COL_W)-1:0] idx,
  input  logic [$clog2(MAXK+1)-1:0]     cnt,
  output logic                          row_pair,
  output logic                          col_pair
);
  localparam int IDX_W = ROW_W + COL_W;
  localparam int CNT_W = $clog2(MAXK + 1);

  logic [MAXK*MAXK-1:0] rp;
  logic [MAXK*MAXK-1:0] cp;

  // one comparator pair per unordered pair of slots
  for (genvar a = 0; a < MAXK; a++) begin : g_a
    for (genvar b = 0; b < MAXK; b++) begin : g_b
      if (b > a) begin : g_pair
        assign rp[a*MAXK+b] = (cnt > CNT_W'(b)) &&
          (idx[a*IDX_W+COL_W +: ROW_W] == idx[b*IDX_W+COL_W +: ROW_W]);
        assign cp[a*MAXK+b] = (cnt > CNT_W'(b)) &&
          (idx[a*IDX_W +: COL_W] == idx[b*IDX_W +: COL_W]);
      end else begin : g_none
        assign rp[a*MAXK+b] = 1'b0;
        assign cp[a*MAXK+b] = 1'b0;
      end
    end
  end

  assign row_pair = |rp;
  assign col_pair = |cp;
endmodule

// File: rtl/key_event_reporter.sv
module key_event_reporter
  import kev_pkg::*;
#(
  parameter int          MAXK    = 8,
  parameter int          ROW_W   = 4,
  parameter int          COL_W   = 3,
  parameter int          KC_W    = 16,
  parameter logic [15:0] FN_CODE = 16'h01D0
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           cfg_ghost_en,
  input  logic                           cfg_fn_en,
  input  logic                           map_we,
  input  logic [ROW_W+COL_W:0]           map_waddr,
  input  logic [KC_W-1:0]                map_wdata,
  input  logic                           snap_valid,
  output logic                           snap_ready,
  input  logic [$clog2(MAXK+1)-1:0]      snap_count,
  input  logic [MAXK*(ROW_W+COL_W)-1:0]  snap_keys,
  output logic                           ev_valid,
  input  logic                           ev_ready,
  output logic [1:0]                     ev_kind,
  output logic [KC_W-1:0]                ev_code
);
  localparam int IDX_W  = ROW_W + COL_W;
  localparam int ADDR_W = IDX_W + 1;
  localparam int CNT_W  = $clog2(MAXK + 1);
  localparam int SEL_W  = (MAXK > 1) ? $clog2(MAXK) : 1;

  typedef enum logic [3:0] {
    S_IDLE, S_RD, S_CAP, S_GHOST, S_FRD, S_FCAP, S_REL, S_PRS, S_DONE
  } state_t;

  state_t            st;
  logic [CNT_W-1:0]  i, cnt_in, new_n, prev_n;
  logic              sub, fn_hit;
  logic [IDX_W-1:0]  raw_idx [MAXK];
  logic [ADDR_W-1:0] new_sc  [MAXK];
  logic [KC_W-1:0]   new_kc  [MAXK];
  logic [KC_W-1:0]   prev_kc [MAXK];

  logic [SEL_W-1:0]  isel, nsel;
  logic [ADDR_W-1:0] map_raddr;
  logic [KC_W-1:0]   map_rdata;
  logic              slot_free, found, row_pair, col_pair, ghost_hit;
  logic [MAXK*IDX_W-1:0] gh_idx;

  assign isel       = i[SEL_W-1:0];
  assign nsel       = new_n[SEL_W-1:0];
  assign slot_free  = !ev_valid || ev_ready;
  assign snap_ready = (st == S_IDLE);

  // address select: base bank during first pass, upper bank on remap
  always_comb begin
    if (st == S_FRD) map_raddr = {1'b1, new_sc[isel][IDX_W-1:0]};
    else             map_raddr = {1'b0, raw_idx[isel]};
  end

  kev_keymap #(.ADDR_W(ADDR_W), .DATA_W(KC_W)) u_map (
    .clk   (clk),
    .we    (map_we),
    .waddr (map_waddr),
    .wdata (map_wdata),
    .raddr (map_raddr),
    .rdata (map_rdata)
  );

  always_comb begin
    for (int k = 0; k < MAXK; k++) gh_idx[k*IDX_W +: IDX_W] = new_sc[k][IDX_W-1:0];
  end

  kev_ghost #(.MAXK(MAXK), .ROW_W(ROW_W), .COL_W(COL_W)) u_ghost (
    .idx      (gh_idx),
    .cnt      (new_n),
    .row_pair (row_pair),
    .col_pair (col_pair)
  );

  assign ghost_hit = cfg_ghost_en && (new_n >= CNT_W'(3)) && row_pair && col_pair;

  // is the stored keycode under review still present in the new list
  always_comb begin
    found = 1'b0;
    for (int j = 0; j < MAXK; j++)
      if ((CNT_W'(j) < new_n) && (new_kc[j] == prev_kc[isel])) found = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      i        <= '0;
      cnt_in   <= '0;
      new_n    <= '0;
      prev_n   <= '0;
      sub      <= 1'b0;
      fn_hit   <= 1'b0;
      ev_valid <= 1'b0;
      ev_kind  <= EV_RELEASE;
      ev_code  <= '0;
      for (int k = 0; k < MAXK; k++) begin
        raw_idx[k] <= '0;
        new_sc[k]  <= '0;
        new_kc[k]  <= '0;
        prev_kc[k] <= '0;
      end
    end else begin
      if (ev_valid && ev_ready) ev_valid <= 1'b0;
      case (st)
        S_IDLE: if (snap_valid) begin
          for (int k = 0; k < MAXK; k++) raw_idx[k] <= snap_keys[k*IDX_W +: IDX_W];
          cnt_in <= (snap_count > CNT_W'(MAXK)) ? CNT_W'(MAXK) : snap_count;
          i      <= '0;
          new_n  <= '0;
          fn_hit <= 1'b0;
          st     <= S_RD;
        end
        S_RD: st <= (i == cnt_in) ? S_GHOST : S_CAP;
        S_CAP: begin
          if (cfg_fn_en && (map_rdata == KC_W'(FN_CODE))) begin
            fn_hit <= 1'b1;
          end else begin
            new_sc[nsel] <= {1'b0, raw_idx[isel]};
            new_kc[nsel] <= map_rdata;
            new_n        <= new_n + 1'b1;
          end
          i  <= i + 1'b1;
          st <= S_RD;
        end
        S_GHOST: begin
          i <= '0;
          if (ghost_hit)   st <= S_IDLE;
          else if (fn_hit) st <= S_FRD;
          else             st <= S_REL;
        end
        S_FRD: if (i == new_n) begin
          i  <= '0;
          st <= S_REL;
        end else begin
          st <= S_FCAP;
        end
        S_FCAP: begin
          new_sc[isel][IDX_W] <= 1'b1;
          new_kc[isel]        <= map_rdata;
          i  <= i + 1'b1;
          st <= S_FRD;
        end
        S_REL: if (i == prev_n) begin
          i   <= '0;
          sub <= 1'b0;
          st  <= S_PRS;
        end else if (found) begin
          i <= i + 1'b1;
        end else if (slot_free) begin
          ev_valid <= 1'b1;
          ev_kind  <= EV_RELEASE;
          ev_code  <= prev_kc[isel];
          i        <= i + 1'b1;
        end
        S_PRS: if (i == new_n) begin
          for (int k = 0; k < MAXK; k++) prev_kc[k] <= new_kc[k];
          prev_n <= new_n;
          st     <= S_DONE;
        end else if (slot_free) begin
          ev_valid <= 1'b1;
          if (!sub) begin
            ev_kind <= EV_SCAN;
            ev_code <= KC_W'(new_sc[isel]);
            sub     <= 1'b1;
          end else begin
            ev_kind <= EV_PRESS;
            ev_code <= new_kc[isel];
            sub     <= 1'b0;
            i       <= i + 1'b1;
          end
        end
        S_DONE: if (slot_free) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1: reset leaves the block idle with no event
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (snap_ready && !ev_valid));

  // R12: a stalled event holds its content
  a_r12_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && !ev_ready) |=> (ev_valid && $stable(ev_kind) && $stable(ev_code)));

  // R12: no snapshot is taken while an event is outstanding
  a_r12_no_accept_busy: assert property (@(posedge clk) disable iff (rst)
    snap_ready |-> !ev_valid);

  // R5: a taken scan event is followed at once by its press event
  a_r5_scan_then_press: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_ready && ev_kind == EV_SCAN) |=> (ev_valid && ev_kind == EV_PRESS));

  // R4: no release follows a press within a snapshot
  a_r4_release_first: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_ready && ev_kind == EV_PRESS) |=> !(ev_valid && ev_kind == EV_RELEASE));
endmodule

// File: tb/key_event_reporter_test.sv
module key_event_reporter_test;
  localparam logic [15:0] FN = 16'h01D0;
  localparam int FN_IDX = 23;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_ghost_en = 1'b1, cfg_fn_en = 1'b1;
  logic        map_we = 1'b0;
  logic [7:0]  map_waddr = '0;
  logic [15:0] map_wdata = '0;
  logic        snap_valid = 1'b0;
  logic        snap_ready;
  logic [3:0]  snap_count = '0;
  logic [55:0] snap_keys = '0;
  logic        ev_valid;
  logic        ev_ready = 1'b0;
  logic [1:0]  ev_kind;
  logic [15:0] ev_code;

  always #4 clk = ~clk;

  key_event_reporter uut (
    .clk(clk), .rst(rst), .cfg_ghost_en(cfg_ghost_en), .cfg_fn_en(cfg_fn_en),
    .map_we(map_we), .map_waddr(map_waddr), .map_wdata(map_wdata),
    .snap_valid(snap_valid), .snap_ready(snap_ready), .snap_count(snap_count),
    .snap_keys(snap_keys), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_kind(ev_kind), .ev_code(ev_code)
  );

  int checks = 0, errors = 0;
  bit stall = 1'b0;
  int got_n = 0;
  logic [17:0] got_ev [64];
  int exp_n = 0;
  logic [17:0] exp_ev [64];
  logic [15:0] mprev [8];
  int mprev_n = 0;

  task automatic check(bit ok, string tag, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [15:0] mapval(int a);
    if (a == FN_IDX) return FN;
    return 16'h2000 + 16'(a);
  endfunction

  // bench model of one snapshot
  task automatic model(int n, logic [6:0] k [8]);
    logic [7:0]  sc [8];
    logic [15:0] kc [8];
    int nd = 0;
    bit fnh = 0, rp = 0, cp = 0;
    exp_n = 0;
    for (int a = 0; a < n; a++) begin
      if (cfg_fn_en && mapval(int'(k[a])) == FN) fnh = 1;
      else begin
        sc[nd] = {1'b0, k[a]};
        kc[nd] = mapval(int'(k[a]));
        nd++;
      end
    end
    if (cfg_ghost_en && nd >= 3) begin
      for (int a = 0; a < nd; a++)
        for (int b = a + 1; b < nd; b++) begin
          if (sc[a][6:3] == sc[b][6:3]) rp = 1;
          if (sc[a][2:0] == sc[b][2:0]) cp = 1;
        end
      if (rp && cp) return;
    end
    if (fnh)
      for (int a = 0; a < nd; a++) begin
        sc[a][7] = 1'b1;
        kc[a] = mapval(int'(sc[a]));
      end
    for (int a = 0; a < mprev_n; a++) begin
      bit hit = 0;
      for (int b = 0; b < nd; b++) if (kc[b] == mprev[a]) hit = 1;
      if (!hit) begin exp_ev[exp_n] = {2'd0, mprev[a]}; exp_n++; end
    end
    for (int a = 0; a < nd; a++) begin
      exp_ev[exp_n] = {2'd2, 8'h00, sc[a]}; exp_n++;
      exp_ev[exp_n] = {2'd1, kc[a]};        exp_n++;
    end
    for (int a = 0; a < nd; a++) mprev[a] = kc[a];
    mprev_n = nd;
  endtask

  task automatic start_snap(int n, logic [6:0] k [8]);
    bit acc;
    model(n, k);
    got_n = 0;
    @(negedge clk);
    snap_valid = 1'b1;
    snap_count = 4'(n);
    for (int a = 0; a < 8; a++) snap_keys[a*7 +: 7] = k[a];
    forever begin
      acc = snap_ready;
      @(negedge clk);
      if (acc) break;
    end
    snap_valid = 1'b0;
  endtask

  task automatic finish_snap(string tag);
    while (!snap_ready) @(negedge clk);
    check(got_n == exp_n, tag, got_n, exp_n);
    for (int a = 0; a < got_n && a < exp_n; a++)
      check(got_ev[a] == exp_ev[a], tag, got_ev[a], exp_ev[a]);
  endtask

  task automatic snap(int n, logic [6:0] k [8], string tag);
    start_snap(n, k);
    finish_snap(tag);
  endtask

  // consumer with random back-pressure
  initial begin
    forever begin
      @(negedge clk);
      ev_ready = stall ? 1'b0 : (($urandom % 4) != 0);
      if (ev_valid && ev_ready && got_n < 64) begin
        got_ev[got_n] = {ev_kind, ev_code};
        got_n++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [6:0] k [8];
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(snap_ready == 1'b1, "R1 ready after reset", snap_ready, 1);
    check(ev_valid == 1'b0, "R1 no event after reset", ev_valid, 0);

    for (int a = 0; a < 256; a++) begin
      map_we = 1'b1; map_waddr = 8'(a); map_wdata = mapval(a);
      @(negedge clk);
    end
    map_we = 1'b0;

    for (int a = 0; a < 8; a++) k[a] = '0;
    k[0] = 7'd26; k[1] = 7'd5;
    snap(2, k, "R1 R2 R3 R5 first snapshot");
    k[0] = 7'd5; k[1] = 7'd40;
    snap(2, k, "R4 R6 release then press");
    k[0] = 7'd0; k[1] = 7'd1; k[2] = 7'd8;
    snap(3, k, "R7 rectangle dropped");
    k[0] = 7'd5;
    snap(1, k, "R7 stored set unchanged");
    k[0] = 7'd0; k[1] = 7'd1; k[2] = 7'd19; k[3] = 7'd27;
    snap(4, k, "R7 disjoint pairs dropped");
    cfg_ghost_en = 1'b0;
    k[0] = 7'd0; k[1] = 7'd1; k[2] = 7'd8;
    snap(3, k, "R8 filter disabled");
    cfg_ghost_en = 1'b1;
    k[0] = 7'd0; k[1] = 7'd1;
    snap(2, k, "R8 fewer than three keys");
    k[0] = 7'd23; k[1] = 7'd5; k[2] = 7'd40;
    snap(3, k, "R9 function layer");
    cfg_fn_en = 1'b0;
    k[0] = 7'd23; k[1] = 7'd5;
    snap(2, k, "R10 function key reported");
    cfg_fn_en = 1'b1;
    snap(0, k, "R11 empty snapshot releases all");
    k[0] = 7'd99;
    snap(1, k, "R11 stored set cleared");
    snap(0, k, "R11 empty again");

    // stalled consumer
    stall = 1'b1;
    k[0] = 7'd5; k[1] = 7'd40;
    start_snap(2, k);
    repeat (30) @(negedge clk);
    check(ev_valid == 1'b1, "R12 event pending in stall", ev_valid, 1);
    check(snap_ready == 1'b0, "R12 busy while pending", snap_ready, 0);
    check({ev_kind, ev_code} == exp_ev[0], "R12 held event", {ev_kind, ev_code}, exp_ev[0]);
    stall = 1'b0;
    finish_snap("R12 after stall");

    // oversize count clamps to eight entries
    for (int a = 0; a < 8; a++) k[a] = 7'(a * 9 + 2);
    cfg_ghost_en = 1'b0;
    start_snap(8, k);
    snap_count = 4'd0;
    finish_snap("R2 eight entries");
    @(negedge clk);
    snap_valid = 1'b1; snap_count = 4'd12;
    mprev_n = mprev_n; model(8, k); got_n = 0;
    begin
      bit acc;
      forever begin acc = snap_ready; @(negedge clk); if (acc) break; end
    end
    snap_valid = 1'b0;
    finish_snap("R2 count clamp");

    // random snapshots
    for (int t = 0; t < 150; t++) begin
      int n;
      cfg_ghost_en = ($urandom % 3) != 0;
      cfg_fn_en = ($urandom % 2) != 0;
      n = $urandom % 9;
      for (int a = 0; a < 8; a++) k[a] = '0;
      for (int a = 0; a < n; a++) begin
        bit dup;
        do begin
          k[a] = (($urandom % 6) == 0) ? 7'(FN_IDX) : 7'($urandom % 128);
          dup = 0;
          for (int b = 0; b < a; b++) if (k[b] == k[a]) dup = 1;
        end while (dup);
      end
      snap(n, k, "R4 R5 R7 R9 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule